// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the command layer of a serial EEPROM. A separate bit-level SPI slave turns the serial line into whole received bytes and accepts whole bytes to shift out. It also reports chip-select edges and how many bits of the current byte had arrived when chip-select rose. The sequencer decodes the first byte of each transaction as an opcode. It then collects a two-byte address, streams array data or status back, or gathers a page of write data into a buffer. The array holds DEPTH bytes in registers.

A write commits only when chip-select rises cleanly on a byte boundary and the enable latch is set. The rise starts a self-timed busy period of WRITE_CYCLES clocks. During the first PAGE clocks of that period the buffered bytes are copied into the array one slot per clock. Each copy is offered to an external protection unit, which may veto it. A status-register write is passed to the same unit as a one-cycle event. The sequencer does not decode protect bits. WRITE_CYCLES must be at least PAGE.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: An opcode is recognised only when bits 7:4 are zero. Bits 2:0 select the command: 110 sets the enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array. Bit 3 has no effect on decoding.
- R2: Any other first byte makes the block ignore all input until the next chip-select fall. In that time tx_en_o stays low and no tx_load_o pulse occurs.
- R3: A status read returns {sr_hi_i, enable latch, busy} with the busy flag in bit 0 and the enable latch in bit 1. The byte is reloaded after every further received byte. While busy it returns 8'hFF.
- R4: An array read takes a high and a low address byte. Only the low AW bits of the 16-bit field are used. The addressed byte is loaded right after the low address byte. Each further received byte loads the next address, and the address wraps from DEPTH-1 to 0.
- R5: An array write stores data bytes into a PAGE-byte buffer. Only the low log2(PAGE) address bits advance, so bytes beyond the page end wrap to the page start and overwrite earlier bytes.
- R6: A write is launched only by a chip-select rise with bit count 0 after at least one data byte. A rise at any other bit count abandons the write and leaves the array unchanged.
- R7: If the enable latch is clear, an array or status write is ignored on the chip-select rise and no busy period starts.
- R8: A launch holds busy_o high for exactly WRITE_CYCLES clocks. During that time every opcode other than status read is ignored, so reads do not drive tx_en_o and the enable latch cannot be set.
- R9: During the busy period each buffered byte is written to {page, slot} only when prot_ok_i is high for that address while prot_chk_o offers it. Unbuffered slots are not written.
- R10: The enable latch is cleared at the chip-select rise that ends any array write or status write, whether or not the write was launched.
- R11: A launched status write emits one sr_wr_o pulse carrying the first data byte on sr_wdata_o, and starts the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_fall_i | input | 1 | Chip-select fall pulse; starts a transaction |
| cs_rise_i | input | 1 | Chip-select rise pulse; ends a transaction |
| bit_cnt_i | input | 3 | Bits of the current byte received at the rise |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_byte_o | output | 8 | Next byte to shift out |
| tx_load_o | output | 1 | One-cycle strobe: tx_byte_o is new |
| tx_en_o | output | 1 | Serial output should be driven |
| busy_o | output | 1 | Self-timed write in progress |
| prot_chk_o | output | 1 | A buffered byte is offered for commit |
| prot_addr_o | output | AW | Address of the offered byte |
| prot_ok_i | input | 1 | Protection unit permits prot_addr_o |
| sr_hi_i | input | 6 | Upper status bits supplied by the protection unit |
| sr_wr_o | output | 1 | Status-write event pulse |
| sr_wdata_o | output | 8 | Status byte written |

## Verification
The embedded properties watch behaviour that holds on every cycle. Any load issued while busy carries 8'hFF. An ignored transaction never loads output. A misaligned or unenabled chip-select rise never starts busy. The page number stays fixed while data streams in. A launch always leaves the enable latch clear and a status event always coincides with busy. The busy counter also runs to its full length. Array content is left to the bench's scenarios, which compare against a bench-side memory model. These cover page wrap with overwrite, read rollover at the top address, protected addresses, commands attempted while busy and abandoned writes.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WEN, OP_WDIS, OP_SRD, OP_SWR, OP_RD, OP_WR
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_AHI, S_ALO, S_RD, S_WR, S_SRD, S_SWR, S_DONE, S_IGN
  } st_e;
endpackage

// File: rtl/eeprom_op_dec.sv
module eeprom_op_dec
  import eeprom_seq_pkg::*;
(
  input  logic [7:0] op_i,
  output op_e        kind_o
);
  always_comb begin
    kind_o = OP_NONE;
    if (op_i[7:4] == 4'h0) begin
      unique case (op_i[2:0])
        3'b110:  kind_o = OP_WEN;
        3'b100:  kind_o = OP_WDIS;
        3'b101:  kind_o = OP_SRD;
        3'b001:  kind_o = OP_SWR;
        3'b011:  kind_o = OP_RD;
        3'b010:  kind_o = OP_WR;
        default: kind_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
  parameter int CYCLES = 5000,
  parameter int CW     = $clog2(CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [CW-1:0] elapsed_o
);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign busy_o    = busy_q;
  assign elapsed_o = cnt_q;

  AST_BUSY_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1))); // R8
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE = 32,
  parameter int PW   = $clog2(PAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [PW-1:0] widx_i,
  input  logic [7:0]    wdata_i,
  input  logic [PW-1:0] ridx_i,
  output logic [7:0]    rdata_o,
  output logic          rvld_o
);
  logic [7:0]      dat_q [PAGE];
  logic [PAGE-1:0] vld_q;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (widx_i == PW'(g));

    always_ff @(posedge clk_i) begin
      if (hit) dat_q[g] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_q[g] <= 1'b0;
      else if (clr_i) vld_q[g] <= 1'b0;
      else if (hit)   vld_q[g] <= 1'b1;
    end
  end

  assign rdata_o = dat_q[ridx_i];
  assign rvld_o  = vld_q[ridx_i];
endmodule

// File: rtl/eeprom_mem.sv
module eeprom_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int DEPTH        = 2048,
  parameter int PAGE         = 32,
  parameter int WRITE_CYCLES = 5000,
  parameter int AW           = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_fall_i,
  input  logic          cs_rise_i,
  input  logic [2:0]    bit_cnt_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_byte_i,
  output logic [7:0]    tx_byte_o,
  output logic          tx_load_o,
  output logic          tx_en_o,
  output logic          busy_o,
  output logic          prot_chk_o,
  output logic [AW-1:0] prot_addr_o,
  input  logic          prot_ok_i,
  input  logic [5:0]    sr_hi_i,
  output logic          sr_wr_o,
  output logic [7:0]    sr_wdata_o
);
  localparam int PW = $clog2(PAGE);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  st_e           st_q;
  op_e           op_kind;
  logic          wel_q, rd_q, got_q, pg_kind_q;
  logic [7:0]    ahi_q;
  logic [AW-1:0] addr_q, new_addr, rd_addr;
  logic [AW-PW-1:0] pg_q;
  logic [7:0]    tx_byte_q, sr_data_q, mem_rdata, buf_rdata, status_byte;
  logic          tx_load_q, sr_wr_q;
  logic          busy, start, buf_clr, buf_wr, buf_vld, commit_act, mem_we;
  logic [CW-1:0] elapsed;
  logic          byte_ev, rise_ev;

  eeprom_op_dec u_dec (.op_i(rx_byte_i), .kind_o(op_kind));

  assign byte_ev  = rx_valid_i && !cs_fall_i && !cs_rise_i;
  assign rise_ev  = cs_rise_i && !cs_fall_i;
  assign new_addr = AW'({ahi_q, rx_byte_i});
  assign rd_addr  = (st_q == S_ALO) ? new_addr : addr_q;
  assign status_byte = busy ? 8'hFF : {sr_hi_i, wel_q, 1'b0};

  // launch: clean byte boundary, enabled, at least one data byte
  assign start   = rise_ev && (st_q == S_WR || st_q == S_SWR) && wel_q && got_q
                   && (bit_cnt_i == 3'd0) && !busy;
  assign buf_clr = byte_ev && st_q == S_OPC && !busy && op_kind == OP_WR;
  assign buf_wr  = byte_ev && st_q == S_WR;

  eeprom_busy_timer #(.CYCLES(WRITE_CYCLES), .CW(CW)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .elapsed_o(elapsed)
  );

  eeprom_page_buf #(.PAGE(PAGE), .PW(PW)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .widx_i(addr_q[PW-1:0]), .wdata_i(rx_byte_i),
    .ridx_i(elapsed[PW-1:0]), .rdata_o(buf_rdata), .rvld_o(buf_vld)
  );

  // commit walker: one page slot per clock at the head of the busy period
  assign commit_act  = busy && pg_kind_q && (32'(elapsed) < PAGE);
  assign prot_addr_o = {pg_q, elapsed[PW-1:0]};
  assign prot_chk_o  = commit_act && buf_vld;
  assign mem_we      = prot_chk_o && prot_ok_i;

  eeprom_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(prot_addr_o), .wdata_i(buf_rdata),
    .raddr_i(rd_addr), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      wel_q     <= 1'b0;
      rd_q      <= 1'b0;
      got_q     <= 1'b0;
      pg_kind_q <= 1'b0;
      ahi_q     <= '0;
      addr_q    <= '0;
      pg_q      <= '0;
      tx_byte_q <= '0;
      tx_load_q <= 1'b0;
      sr_wr_q   <= 1'b0;
      sr_data_q <= '0;
    end else begin
      tx_load_q <= 1'b0;
      sr_wr_q   <= 1'b0;
      if (cs_fall_i) begin
        st_q <= S_OPC;
      end else if (cs_rise_i) begin
        st_q <= S_IDLE;
        if (st_q == S_WR || st_q == S_SWR) wel_q <= 1'b0;
        if (start) begin
          pg_kind_q <= (st_q == S_WR);
          pg_q      <= addr_q[AW-1:PW];
          sr_wr_q   <= (st_q == S_SWR);
        end
      end else if (rx_valid_i) begin
        unique case (st_q)
          S_OPC: begin
            if (busy && op_kind != OP_SRD) st_q <= S_IGN;
            else begin
              unique case (op_kind)
                OP_WEN:  begin wel_q <= 1'b1; st_q <= S_DONE; end
                OP_WDIS: begin wel_q <= 1'b0; st_q <= S_DONE; end
                OP_SRD:  begin tx_byte_q <= status_byte; tx_load_q <= 1'b1; st_q <= S_SRD; end
                OP_SWR:  begin got_q <= 1'b0; st_q <= S_SWR; end
                OP_RD:   begin rd_q <= 1'b1; st_q <= S_AHI; end
                OP_WR:   begin rd_q <= 1'b0; got_q <= 1'b0; st_q <= S_AHI; end
                default: st_q <= S_IGN;
              endcase
            end
          end
          S_AHI: begin
            ahi_q <= rx_byte_i;
            st_q  <= S_ALO;
          end
          S_ALO: begin
            if (rd_q) begin
              tx_byte_q <= mem_rdata;
              tx_load_q <= 1'b1;
              addr_q    <= new_addr + AW'(1);
              st_q      <= S_RD;
            end else begin
              addr_q <= new_addr;
              st_q   <= S_WR;
            end
          end
          S_RD: begin
            tx_byte_q <= mem_rdata;
            tx_load_q <= 1'b1;
            addr_q    <= addr_q + AW'(1);
          end
          S_SRD: begin
            tx_byte_q <= status_byte;
            tx_load_q <= 1'b1;
          end
          S_WR: begin
            addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
            got_q  <= 1'b1;
          end
          S_SWR: begin
            if (!got_q) begin
              sr_data_q <= rx_byte_i;
              got_q     <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_byte_o  = tx_byte_q;
  assign tx_load_o  = tx_load_q;
  assign tx_en_o    = (st_q == S_RD) || (st_q == S_SRD);
  assign busy_o     = busy;
  assign sr_wr_o    = sr_wr_q;
  assign sr_wdata_o = sr_data_q;

  AST_BUSY_LOADS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tx_load_o) |-> (tx_byte_o == 8'hFF)); // R3
  AST_IGNORED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IGN && byte_ev) |=> !tx_load_o); // R2
  AST_MISALIGNED_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && bit_cnt_i != 3'd0 && !busy_o) |=> !busy_o); // R6
  AST_UNENABLED_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !wel_q && !busy_o) |=> !busy_o); // R7
  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WR && $past(st_q) == S_WR) |-> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]))); // R5
  AST_LAUNCH_CLEARS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !wel_q); // R10
  AST_SR_EVENT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_o |-> (busy_o && $rose(busy_o))); // R11
endmodule

// File: tb/eeprom_cmd_seq_bench.sv
module eeprom_cmd_seq_bench;
  localparam int DEPTH = 2048;
  localparam int WC    = 40;
  localparam logic [5:0] SR_HI = 6'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_fall = 1'b0, cs_rise = 1'b0, rx_valid = 1'b0;
  logic [2:0]  bit_cnt = 3'd0;
  logic [7:0]  rx_byte = 8'h00;
  logic [7:0]  tx_byte, sr_wdata;
  logic        tx_load, tx_en, busy, prot_chk, prot_ok, sr_wr;
  logic [10:0] prot_addr;
  logic [11:0] lock_base = 12'd2048;

  logic [7:0]  ref_mem [DEPTH];
  logic        wel_m = 1'b0;
  int checks = 0, fails = 0;
  int ld_cnt = 0, sr_cnt = 0, busy_run = 0, last_busy = 0;
  logic [7:0] sr_last = 8'h00;

  always #2 clk = ~clk;

  assign prot_ok = ({1'b0, prot_addr} < lock_base);

  eeprom_cmd_seq #(.DEPTH(DEPTH), .PAGE(32), .WRITE_CYCLES(WC)) u_eeprom_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .bit_cnt_i(bit_cnt), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_byte_o(tx_byte), .tx_load_o(tx_load), .tx_en_o(tx_en), .busy_o(busy),
    .prot_chk_o(prot_chk), .prot_addr_o(prot_addr), .prot_ok_i(prot_ok),
    .sr_hi_i(SR_HI), .sr_wr_o(sr_wr), .sr_wdata_o(sr_wdata)
  );

  always @(posedge clk) begin
    if (tx_load) ld_cnt++;
    if (sr_wr) begin sr_cnt++; sr_last = sr_wdata; end
    if (busy) busy_run++;
    else if (busy_run != 0) begin last_busy = busy_run; busy_run = 0; end
  end

  function automatic logic [7:0] exp_status(input logic w);
    return {SR_HI, w, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk); cs_fall = 1'b1;
    @(negedge clk); cs_fall = 1'b0;
  endtask

  task automatic cs_end(input logic [2:0] bits);
    @(negedge clk); cs_rise = 1'b1; bit_cnt = bits;
    @(negedge clk); cs_rise = 1'b0; bit_cnt = 3'd0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic one_byte_cmd(input logic [7:0] opc);
    cs_begin(); send(opc); cs_end(3'd0);
  endtask

  task automatic status_read(output logic [7:0] s);
    cs_begin(); send(8'h05); s = tx_byte; cs_end(3'd0);
  endtask

  task automatic read_check(input logic [10:0] a, input int n, input logic [7:0] opc, input string tag);
    logic [10:0] ia;
    cs_begin(); send(opc);
    send({5'b10101, a[10:8]});   // upper five bits must be ignored
    send(a[7:0]);
    chk(tx_en == 1'b1 && tx_byte == ref_mem[a], tag, {23'd0, tx_en, tx_byte}, {24'd1, ref_mem[a]});
    for (int k = 1; k < n; k++) begin
      send(8'($urandom));
      ia = a + 11'(k);
      chk(tx_byte == ref_mem[ia], tag, tx_byte, ref_mem[ia]);
    end
    cs_end(3'd0);
  endtask

  // full write flow with bench-side commit model
  task automatic page_write(input logic [10:0] a, input int n, input bit wren,
                            input logic [2:0] bits, input bit wait_done, output bit launched);
    logic [7:0] pb [32];
    bit         pv [32];
    logic [10:0] aa;
    for (int i = 0; i < 32; i++) begin pv[i] = 1'b0; pb[i] = 8'h00; end
    if (wren) begin one_byte_cmd(8'h06); wel_m = 1'b1; end
    cs_begin();
    send(8'h02 | 8'(($urandom % 2) << 3));
    send({5'b00000, a[10:8]});
    send(a[7:0]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      int idx;
      d = 8'($urandom);
      idx = (int'(a[4:0]) + k) % 32;
      pb[idx] = d; pv[idx] = 1'b1;
      send(d);
    end
    cs_end(bits);
    launched = wel_m && bits == 3'd0 && n > 0;
    wel_m = 1'b0;
    if (launched) begin
      for (int i = 0; i < 32; i++) begin
        aa = {a[10:5], 5'(i)};
        if (pv[i] && ({1'b0, aa} < lock_base)) ref_mem[aa] = pb[i];
      end
      if (wait_done) repeat (WC + 3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s;
    bit l;
    int ld0, sr0;
    logic [10:0] ra;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R3)
    chk(!tx_en && !busy && !tx_load && !sr_wr, "R3 reset outputs", {tx_en, busy, tx_load, sr_wr}, 0);
    status_read(s);
    chk(s == exp_status(1'b0), "R3 status after reset", s, exp_status(1'b0));

    // prefill whole array, full pages (R5)
    for (int p = 0; p < DEPTH / 32; p++) page_write(11'(p * 32), 32, 1'b1, 3'd0, 1'b1, l);
    for (int i = 0; i < 6; i++) read_check(11'($urandom % DEPTH), 4, 8'h03, "R4 prefill readback");

    // R3 enable/disable latch via status
    one_byte_cmd(8'h06);
    status_read(s);
    chk(s == exp_status(1'b1), "R3 enable latch set", s, exp_status(1'b1));
    one_byte_cmd(8'h04);
    status_read(s);
    chk(s == exp_status(1'b0), "R3 enable latch cleared", s, exp_status(1'b0));

    // R1 bit 3 ignored; upper nibble nonzero rejected
    one_byte_cmd(8'h0E);
    status_read(s);
    chk(s == exp_status(1'b1), "R1 enable with bit3 set", s, exp_status(1'b1));
    one_byte_cmd(8'h0C);
    read_check(11'h123, 3, 8'h0B, "R1 read with bit3 set");
    ld0 = ld_cnt;
    cs_begin(); send(8'h13); send(8'h01); send(8'h23); send(8'h00);
    chk(!tx_en && ld_cnt == ld0, "R1 upper nibble rejects", {tx_en, 8'(ld_cnt - ld0)}, 0);
    cs_end(3'd0);

    // R2 unknown opcode ignored until next fall
    ld0 = ld_cnt;
    cs_begin(); send(8'h07); send(8'h05); send(8'h03); send(8'h00);
    chk(!tx_en && ld_cnt == ld0, "R2 unknown opcode silent", {tx_en, 8'(ld_cnt - ld0)}, 0);
    cs_end(3'd0);
    read_check(11'h040, 2, 8'h03, "R2 recovery after new fall");

    // R4 rollover at top address
    read_check(11'h7FE, 5, 8'h03, "R4 read wrap to zero");

    // R5 page wrap with overwrite
    page_write(11'h25C, 40, 1'b1, 3'd0, 1'b1, l);
    read_check(11'h240, 32, 8'h03, "R5 page wrap overwrite");
    read_check(11'h23F, 2, 8'h03, "R5 neighbour page untouched");
    read_check(11'h25F, 2, 8'h03, "R5 next page untouched");

    // R6 misaligned rise abandons; R10 latch still cleared
    page_write(11'h300, 5, 1'b1, 3'd3, 1'b1, l);
    chk(!busy, "R6 misaligned no busy", busy, 0);
    read_check(11'h300, 5, 8'h03, "R6 misaligned array unchanged");
    status_read(s);
    chk(s == exp_status(1'b0), "R10 latch cleared after abandoned write", s, exp_status(1'b0));
    page_write(11'h320, 0, 1'b1, 3'd0, 1'b1, l);
    chk(!busy, "R6 no data byte no busy", busy, 0);

    // R7 write without enable
    page_write(11'h340, 6, 1'b0, 3'd0, 1'b1, l);
    chk(!busy, "R7 unenabled no busy", busy, 0);
    read_check(11'h340, 6, 8'h03, "R7 unenabled array unchanged");

    // R8 busy window behaviour
    page_write(11'h400, 4, 1'b1, 3'd0, 1'b0, l);
    chk(busy, "R8 busy after launch", busy, 1);
    status_read(s);
    chk(s == 8'hFF, "R8 status during busy", s, 8'hFF);
    cs_begin(); send(8'h03); send(8'h04); send(8'h00);
    chk(!tx_en, "R8 read ignored while busy", tx_en, 0);
    cs_end(3'd0);
    one_byte_cmd(8'h06);
    repeat (WC + 3) @(negedge clk);
    chk(last_busy == WC, "R8 busy length", last_busy, WC);
    status_read(s);
    chk(s == exp_status(1'b0), "R8 enable ignored while busy", s, exp_status(1'b0));
    read_check(11'h400, 4, 8'h03, "R8 committed data");

    // R9 protection veto, half page
    lock_base = 12'h710;
    page_write(11'h700, 32, 1'b1, 3'd0, 1'b1, l);
    read_check(11'h700, 32, 8'h03, "R9 protected slots kept");

    // R11 status write event
    sr0 = sr_cnt;
    one_byte_cmd(8'h06);
    cs_begin(); send(8'h01); send(8'h8C); send(8'h55); cs_end(3'd0);
    chk(busy, "R11 status write busy", busy, 1);
    repeat (WC + 3) @(negedge clk);
    chk(sr_cnt == sr0 + 1 && sr_last == 8'h8C, "R11 status event", {sr_last, 8'(sr_cnt - sr0)}, {8'h8C, 8'd1});
    cs_begin(); send(8'h09); send(8'h33); cs_end(3'd0);
    chk(sr_cnt == sr0 + 1 && !busy, "R7 status write unenabled", sr_cnt - sr0, 1);

    // random mix
    lock_base = 12'h700;
    for (int it = 0; it < 30; it++) begin
      ra = 11'($urandom % DEPTH);
      page_write(ra, 1 + int'($urandom % 40), ($urandom % 4) != 0,
                 (($urandom % 8) == 0) ? 3'(1 + $urandom % 7) : 3'd0, 1'b1, l);
      read_check({ra[10:5], 5'd0}, 32, 8'h03, "R9 random page check");
      read_check(11'($urandom % DEPTH), 1 + int'($urandom % 5), 8'h03, "R4 random read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule